// File: doc/BRIEF.md
# Steerable watchdog timer

This block supervises a processor by counting down a programmable interval and raising an alarm if nothing restarts it in time. One 8-bit configuration byte sets the interval and the alarm style. Bits 6:2 hold a five-bit multiplier M. Bits 1:0 hold a resolution code R, where 0 selects 1/16 s, 1 selects 1/4 s, 2 selects 1 s and 3 selects 4 s. Bit 7 selects the alarm style. The interval is M times the chosen resolution. For example, the byte 0x0E gives 3 s. Time is counted from a base tick input: `SUB_TICKS` ticks make one sixteenth of a second.

Software restarts the interval by writing the configuration byte. An external kick pin restarts it on either a rising or a falling transition. When the interval expires, a sticky timeout flag is set. With bit 7 clear, an interrupt output is raised and held until software writes 0x00. With bit 7 set, an active-low reset pulse lasting `RST_TICKS` base ticks is produced. In that case the configuration byte is also cleared, and a one-cycle strobe tells neighbouring logic to clear its related control bits.

Top module: `wdog_steer`

## Requirements
- R1: A write (`wrEn` high at a clock edge) loads `wrData` into `regOut` after that edge and restarts the interval.
- R2: With multiplier M = bits 6:2 and code R = bits 1:0, the timeout flag rises after exactly M × 4^R × `SUB_TICKS` ticked edges counted from the edge of the last restart.
- R3: When M is zero, no timeout is ever produced.
- R4: Any transition of `kickIn`, rising or falling, restarts the interval. The kick passes through two synchroniser flops, so the restart takes effect at the second clock edge after the first edge that samples the new level. A restart falling on the same edge as an expiry suppresses that expiry.
- R5: On a timeout with bit 7 = 0, `flagOut` and `irqOut` both go high. `irqOut` stays high until a write of 0x00, and a nonzero write leaves it high.
- R6: On a timeout with bit 7 = 1, `flagOut` rises and `irqOut` stays low. `rstOutN` is low for exactly `RST_TICKS` ticked edges. `regOut` becomes 0x00, so no further timeouts follow. `clrCtrl` is high for exactly one cycle.
- R7: `flagAck` clears `flagOut`. A timeout on the same edge takes priority and keeps the flag set.
- R8: After reset, `flagOut`, `irqOut` and `clrCtrl` are low, `rstOutN` is high, and `regOut` is 0x00.
- R9: Time advances only on edges where `tick` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Base time tick enable |
| wrEn | input | 1 | Configuration write strobe |
| wrData | input | 8 | Configuration write data |
| kickIn | input | 1 | Asynchronous kick pin, either edge restarts |
| flagAck | input | 1 | Clears the timeout flag |
| regOut | output | 8 | Current configuration byte |
| flagOut | output | 1 | Sticky timeout flag |
| irqOut | output | 1 | Interrupt output, active high |
| rstOutN | output | 1 | Active-low reset pulse |
| clrCtrl | output | 1 | One-cycle strobe to clear related control bits |

## Verification
The bench builds the block with `SUB_TICKS` = 2 and `RST_TICKS` = 5, and holds `tick` high for most of the run. With these values every resolution code finishes within a few thousand cycles, including the largest setting, 31 × 4 s. The exact cycle of each timeout can therefore be checked for every resolution code and for both ends of the multiplier range. The short reset pulse lets the bench observe both of its edges and the clearing of the configuration byte. The bench also gates `tick` to show that time stops while it is low.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  // Requests from the control module to the datapath
  typedef struct packed {
    logic restart;
    logic clearReg;
  } wdStrobe_t;

  // Status from the datapath to the control module
  typedef struct packed {
    logic expire;
    logic steer;
  } wdStatus_t;
endpackage

// File: rtl/wdog_dp.sv
module wdog_dp
  import wdog_pkg::*;
#(
  parameter int SUB_TICKS = 2048
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  wdStrobe_t  strobe,
  output wdStatus_t  status,
  output logic [7:0] regVal
);
  localparam int MULT_W = 5;
  localparam int MAX_SHIFT = 6;
  localparam int UNIT_W = MULT_W + MAX_SHIFT;
  localparam int PRE_W = (SUB_TICKS > 1) ? $clog2(SUB_TICKS) : 1;

  logic [7:0]        cfgReg;
  logic [PRE_W-1:0]  preCnt;
  logic [UNIT_W-1:0] unitCnt;
  logic [UNIT_W-1:0] target;
  logic [MULT_W-1:0] mult;
  logic [1:0]        resSel;
  logic              enabled, preLast, unitLast;

  assign mult     = cfgReg[6:2];
  assign resSel   = cfgReg[1:0];
  assign enabled  = (mult != '0);
  // The interval in sixteenths of a second: M * 4^R
  assign target   = UNIT_W'(mult) << {resSel, 1'b0};
  assign preLast  = (preCnt == PRE_W'(SUB_TICKS - 1));
  assign unitLast = (unitCnt == target - UNIT_W'(1));

  assign status.expire = enabled & tick & preLast & unitLast;
  assign status.steer  = cfgReg[7];
  assign regVal        = cfgReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgReg <= '0;
    end else if (wrEn) begin
      cfgReg <= wrData;
    end else if (strobe.clearReg) begin
      cfgReg <= '0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt  <= '0;
      unitCnt <= '0;
    end else if (strobe.restart || !enabled) begin
      preCnt  <= '0;
      unitCnt <= '0;
    end else if (tick) begin
      if (preLast) begin
        preCnt  <= '0;
        unitCnt <= unitLast ? '0 : unitCnt + UNIT_W'(1);
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/wdog_ctrl.sv
module wdog_ctrl
  import wdog_pkg::*;
#(
  parameter int RST_TICKS = 6554
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       kickIn,
  input  logic       flagAck,
  input  wdStatus_t  status,
  output wdStrobe_t  strobe,
  output logic       flagOut,
  output logic       irqOut,
  output logic       rstOutN,
  output logic       clrCtrl
);
  localparam int RC_W = $clog2(RST_TICKS + 1);

  logic            kickMeta, kickSync, kickPrev;
  logic            kickEdge, softRestart, timeout;
  logic [RC_W-1:0] rstCnt;

  assign kickEdge    = kickSync ^ kickPrev;
  assign softRestart = wrEn | kickEdge;
  // A restart on the same edge wins over an expiry
  assign timeout     = status.expire & ~softRestart;

  assign strobe.restart  = softRestart | timeout;
  assign strobe.clearReg = timeout & status.steer;
  assign rstOutN         = (rstCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      kickMeta <= 1'b0;
      kickSync <= 1'b0;
      kickPrev <= 1'b0;
    end else begin
      kickMeta <= kickIn;
      kickSync <= kickMeta;
      kickPrev <= kickSync;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagOut <= 1'b0;
      irqOut  <= 1'b0;
      clrCtrl <= 1'b0;
      rstCnt  <= '0;
    end else begin
      clrCtrl <= timeout & status.steer;
      if (timeout) begin
        flagOut <= 1'b1;
      end else if (flagAck) begin
        flagOut <= 1'b0;
      end
      if (timeout && !status.steer) begin
        irqOut <= 1'b1;
      end else if (wrEn && wrData == 8'h00) begin
        irqOut <= 1'b0;
      end
      if (timeout && status.steer) begin
        rstCnt <= RC_W'(RST_TICKS);
      end else if (tick && rstCnt != '0) begin
        rstCnt <= rstCnt - RC_W'(1);
      end
    end
  end
endmodule

// File: rtl/wdog_steer.sv
module wdog_steer
  import wdog_pkg::*;
#(
  parameter int SUB_TICKS = 2048,
  parameter int RST_TICKS = 6554
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       tick,
  input  logic       wrEn,
  input  logic [7:0] wrData,
  input  logic       kickIn,
  input  logic       flagAck,
  output logic [7:0] regOut,
  output logic       flagOut,
  output logic       irqOut,
  output logic       rstOutN,
  output logic       clrCtrl
);
  wdStrobe_t strobe;
  wdStatus_t status;

  wdog_dp #(.SUB_TICKS(SUB_TICKS)) u_dp (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .wrData(wrData),
    .strobe(strobe), .status(status), .regVal(regOut)
  );

  wdog_ctrl #(.RST_TICKS(RST_TICKS)) u_ctrl (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .wrData(wrData),
    .kickIn(kickIn), .flagAck(flagAck), .status(status), .strobe(strobe),
    .flagOut(flagOut), .irqOut(irqOut), .rstOutN(rstOutN), .clrCtrl(clrCtrl)
  );
endmodule

// File: rtl/wdog_steer_chk.sv
module wdog_steer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       tick,
  input logic       wrEn,
  input logic [7:0] wrData,
  input logic       kickIn,
  input logic       flagAck,
  input logic [7:0] regOut,
  input logic       flagOut,
  input logic       irqOut,
  input logic       rstOutN,
  input logic       clrCtrl
);
  assert_write_load_R1: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> regOut == $past(wrData));

  assert_zero_mult_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagOut) |-> $past(regOut[6:2]) != 5'd0);

  assert_irq_source_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqOut) |-> (!$past(regOut[7]) && flagOut));

  assert_irq_clear_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrData == 8'h00) |=> !irqOut);

  assert_steer_clear_R6: assert property (@(posedge clk) disable iff (!rstN)
    clrCtrl |-> (regOut == 8'h00 && !rstOutN && flagOut));

  assert_pulse_start_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rstOutN) |-> clrCtrl);

  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(flagOut) |-> $past(flagAck));

  logic unusedSig;
  assign unusedSig = tick ^ kickIn;
endmodule

bind wdog_steer wdog_steer_chk u_chk (.*);

// File: tb/wdog_steer_tb.sv
`timescale 1ns/1ps
module wdog_steer_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tick = 1'b1;
  logic       wrEn = 1'b0;
  logic [7:0] wrData = 8'h00;
  logic       kickIn = 1'b0;
  logic       flagAck = 1'b0;
  logic [7:0] regOut;
  logic       flagOut, irqOut, rstOutN, clrCtrl;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  wdog_steer #(.SUB_TICKS(2), .RST_TICKS(5)) u_dut (
    .clk(clk), .rstN(rstN), .tick(tick), .wrEn(wrEn), .wrData(wrData),
    .kickIn(kickIn), .flagAck(flagAck), .regOut(regOut), .flagOut(flagOut),
    .irqOut(irqOut), .rstOutN(rstOutN), .clrCtrl(clrCtrl)
  );

  // Configuration byte and the ticked edges until timeout (M * 4^R * 2)
  localparam logic [7:0] VEC_DATA [7] = '{8'h04, 8'h05, 8'h0C, 8'h0E, 8'h7C, 8'h0B, 8'h7F};
  localparam int         VEC_CYC  [7] = '{2, 8, 6, 96, 62, 256, 3968};

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic waitEdges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic doWrite(input logic [7:0] d);
    @(negedge clk); wrEn = 1'b1; wrData = d;
    @(negedge clk); wrEn = 1'b0;
  endtask

  task automatic pulseAck();
    @(negedge clk); flagAck = 1'b1;
    @(negedge clk); flagAck = 1'b0;
  endtask

  task automatic kickTest(input logic lvl, input string req);
    doWrite(8'h00); pulseAck();
    doWrite(8'h0C);
    waitEdges(3);
    @(negedge clk); kickIn = lvl;
    waitEdges(8);
    check(flagOut == 1'b0, req, flagOut, 0);
    waitEdges(1);
    check(flagOut == 1'b1, req, flagOut, 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    #1;
    check(rstOutN == 1'b1, "R8 reset rstOutN", rstOutN, 1);
    waitEdges(3);
    @(negedge clk); rstN = 1'b1;
    waitEdges(2);
    check(flagOut == 1'b0, "R8 flag", flagOut, 0);
    check(irqOut == 1'b0, "R8 irq", irqOut, 0);
    check(clrCtrl == 1'b0, "R8 clr", clrCtrl, 0);
    check(regOut == 8'h00, "R8 reg", regOut, 0);

    // Table walk: exact timeout cycle per setting in interrupt mode
    for (int i = 0; i < 7; i++) begin
      doWrite(8'h00); pulseAck();
      check(irqOut == 1'b0, "R5 irq cleared by 00h", irqOut, 0);
      doWrite(VEC_DATA[i]);
      check(regOut == VEC_DATA[i], "R1 load", regOut, VEC_DATA[i]);
      waitEdges(VEC_CYC[i] - 1);
      check(flagOut == 1'b0, "R2 early", flagOut, 0);
      waitEdges(1);
      check(flagOut == 1'b1, "R2 on time", flagOut, 1);
      check(irqOut == 1'b1, "R5 irq set", irqOut, 1);
    end

    // Nonzero write keeps irq; 00h write clears it
    doWrite(8'h0C);
    check(irqOut == 1'b1, "R5 nonzero write keeps irq", irqOut, 1);
    doWrite(8'h00);
    check(irqOut == 1'b0, "R5 zero write clears irq", irqOut, 0);
    check(flagOut == 1'b1, "R7 flag sticky", flagOut, 1);
    pulseAck();
    check(flagOut == 1'b0, "R7 ack clears", flagOut, 0);

    // Zero multiplier disables
    doWrite(8'h03);
    waitEdges(5000);
    check(flagOut == 1'b0, "R3 zero multiplier", flagOut, 0);

    // Kick edges of both polarities; kick restart also suppresses the due expiry
    kickTest(1'b1, "R4 rising kick");
    kickTest(1'b0, "R4 falling kick");

    // Tick gating
    doWrite(8'h00); pulseAck();
    @(negedge clk); tick = 1'b0;
    doWrite(8'h04);
    waitEdges(20);
    check(flagOut == 1'b0, "R9 no tick no time", flagOut, 0);
    @(negedge clk); tick = 1'b1;
    waitEdges(1);
    check(flagOut == 1'b0, "R9 first tick", flagOut, 0);
    waitEdges(1);
    check(flagOut == 1'b1, "R9 second tick", flagOut, 1);

    // Reset-steered timeout
    doWrite(8'h00); pulseAck();
    doWrite(8'h84);
    waitEdges(1);
    check(rstOutN == 1'b1, "R6 before timeout", rstOutN, 1);
    waitEdges(1);
    check(flagOut == 1'b1, "R6 flag", flagOut, 1);
    check(rstOutN == 1'b0, "R6 pulse low", rstOutN, 0);
    check(clrCtrl == 1'b1, "R6 clear strobe", clrCtrl, 1);
    check(regOut == 8'h00, "R6 reg cleared", regOut, 0);
    check(irqOut == 1'b0, "R6 no irq", irqOut, 0);
    waitEdges(1);
    check(clrCtrl == 1'b0, "R6 strobe one cycle", clrCtrl, 0);
    waitEdges(3);
    check(rstOutN == 1'b0, "R6 pulse still low", rstOutN, 0);
    waitEdges(1);
    check(rstOutN == 1'b1, "R6 pulse ends", rstOutN, 1);
    pulseAck();
    waitEdges(200);
    check(flagOut == 1'b0, "R6 no further timeout", flagOut, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule